// File: doc/BRIEF.md
# Two-Word Absolute Jump Sequencer

This block sits between instruction fetch and decode in a small core with 8-bit data and 16-bit instruction words. Each instruction cycle lasts four clocks, called phases Q1 to Q4. The word on the fetch port is captured at the end of Q4 into an instruction register, and that register is decoded at Q1 of the next instruction cycle. The block also owns the program counter, which is a byte address whose bit 0 is always zero.

An unconditional absolute jump uses two instruction words. The first word has upper byte 0xEF, and its low byte gives target bits 7:0. The second word has upper nibble 0xF, and its low 12 bits give target bits 19:8. When the first word is decoded, the low byte is captured at the end of Q2. The second word is taken directly from the fetch port at the end of Q4 of that same cycle. The 20-bit target is then written into PC bits 20:1 and a flush pulse is raised. The second word, which the fetch unit loaded behind the jump, is marked dead, so the next instruction cycle executes nothing. The jump therefore always costs exactly two instruction cycles. A word with upper nibble 0xF that is decoded on its own does nothing.

Top module: `jump_seq`

## Requirements
- R1: While rst_n is low, pc_o is 0, phase_o is 0 (Q1), flush_o is 0, and the instruction register holds no live word.
- R2: phase_o steps 0,1,2,3 (Q1..Q4) once per clock and wraps to 0. fetch_req_o is high exactly in phase 0. fetch_addr_o always equals pc_o.
- R3: Outside a jump, at the clock edge that ends Q4, the word on instr_i is captured. If instr_valid_i is high, pc_o advances by 2 (modulo 2^21). If it is low, pc_o holds and the next instruction cycle executes nothing. pc_o never changes at any other edge.
- R4: A live word whose bits 15:8 equal 0xEF, decoded at Q1, starts a jump. Its bits 7:0 become target bits 7:0, which appear as pc_o[8:1].
- R5: At the Q4 edge of the jump's first cycle, instr_i[11:0] supplies target bits 19:8, and pc_o is loaded with {instr_i[11:0], low byte, 1'b0}.
- R6: pc_o[0] is 0 at all times.
- R7: flush_o is high for exactly one clock, during the Q1 phase that follows a jump's PC load, and is low at all other times.
- R8: A live word with bits 15:12 equal to 0xF, decoded on its own, acts as a no-operation. It causes no flush and no PC load.
- R9: The instruction cycle after a jump's PC load is a dead cycle. At its Q4 edge the word at the target is fetched and pc_o becomes target+2, and the next decode is of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one edge per Q phase |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 16 | Instruction word read from fetch_addr_o |
| instr_valid_i | input | 1 | instr_i holds a fetched word (sampled at the Q4 edge) |
| pc_o | output | 21 | Program counter, byte address |
| fetch_addr_o | output | 21 | Address of the word being fetched |
| fetch_req_o | output | 1 | Fetch request, high during Q1 |
| flush_o | output | 1 | One-clock pulse: the word behind a jump is discarded |
| phase_o | output | 2 | Current Q phase, 0 = Q1 to 3 = Q4 |

## Verification
The assertions take two things for granted. First, the fetch port delivers the jump's second word with instr_valid_i high at the Q4 edge of the jump's first cycle. Second, that word carries the 0xF prefix. The design itself consumes the low 12 bits whatever the valid and prefix bits are. The stimulus serves instr_i from a program table indexed by fetch_addr_o, with every second jump word prefixed 0xF. It inserts fetch bubbles only in instruction cycles that are neither inside a jump nor the dead cycle after one. The jump targets include the top of the 2 MB range and address zero, so the PC wraps.

// File: rtl/jump_seq.sv
module jump_seq #(
  parameter logic [7:0] FIRST_TAG = 8'hEF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] instr_i,
  input  logic        instr_valid_i,
  output logic [20:0] pc_o,
  output logic [20:0] fetch_addr_o,
  output logic        fetch_req_o,
  output logic        flush_o,
  output logic [1:0]  phase_o
);
  localparam logic [1:0] Q1 = 2'd0, Q2 = 2'd1, Q4 = 2'd3;

  logic [1:0]  phase;
  logic [20:0] pc;
  logic [15:0] ir;
  logic        ir_live;
  logic        jump_act;
  logic [7:0]  k_lo;
  logic        flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= Q1;
      pc       <= '0;
      ir       <= '0;
      ir_live  <= 1'b0;
      jump_act <= 1'b0;
      k_lo     <= '0;
      flush    <= 1'b0;
    end else begin
      phase <= phase + 2'd1;
      flush <= 1'b0;
      case (phase)
        Q1: jump_act <= ir_live && (ir[15:8] == FIRST_TAG);
        Q2: if (jump_act) k_lo <= ir[7:0];
        Q4: begin
          ir <= instr_i;
          if (jump_act) begin
            pc      <= {instr_i[11:0], k_lo, 1'b0};
            ir_live <= 1'b0;
            flush   <= 1'b1;
          end else begin
            ir_live <= instr_valid_i;
            if (instr_valid_i) pc <= pc + 21'd2;
          end
        end
        default: ;
      endcase
    end
  end

  assign pc_o         = pc;
  assign fetch_addr_o = pc;
  assign fetch_req_o  = (phase == Q1);
  assign flush_o      = flush;
  assign phase_o      = phase;
endmodule

// File: rtl/jump_seq_chk.sv
module jump_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid_i,
  input logic [20:0] pc_o,
  input logic [1:0]  phase_o,
  input logic        flush_o,
  input logic        jump_act
);
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase_o == $past(phase_o) + 2'd1);

  a_r3_pc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != 2'd3) |=> $stable(pc_o));

  a_r3_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd3 && instr_valid_i && !jump_act) |=> pc_o == $past(pc_o) + 21'd2);

  a_r6_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_o[0]);

  a_r7_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);

  a_r7_flush_in_q1: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> phase_o == 2'd0);

  a_r7_flush_after_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd3 && jump_act) |=> flush_o);
endmodule

bind jump_seq jump_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i), .pc_o(pc_o),
  .phase_o(phase_o), .flush_o(flush_o), .jump_act(jump_act)
);

// File: tb/jump_seq_bench.sv
module jump_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr_i = '0;
  logic        instr_valid_i = 1'b1;
  logic [20:0] pc_o, fetch_addr_o;
  logic        fetch_req_o, flush_o;
  logic [1:0]  phase_o;

  jump_seq u_jump_seq (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .instr_valid_i(instr_valid_i),
    .pc_o(pc_o), .fetch_addr_o(fetch_addr_o), .fetch_req_o(fetch_req_o),
    .flush_o(flush_o), .phase_o(phase_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] prog(input int a);
    case (a)
      'h000000: return 16'hF000;
      'h000002: return 16'h1234;
      'h000004: return 16'hEF56;
      'h000006: return 16'hF234;
      'h0468AC: return 16'hEFFF;
      'h0468AE: return 16'hFFFF;
      'h1FFFFE: return 16'hEF00;
      default:  return 16'h0AAA;
    endcase
  endfunction

  // reference model, advanced on every rising edge
  int m_ph, m_pc, m_word, m_klo;
  bit m_live, m_jmp, m_flush;
  bit lone_pend; int lone_pc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_pc = 0; m_word = 0; m_klo = 0;
      m_live = 0; m_jmp = 0; m_flush = 0; lone_pend = 0;
    end else begin
      m_flush = 0;
      if (m_ph == 0) begin
        m_jmp = m_live && ((m_word >> 8) == 'hEF);
        if (m_live && ((m_word >> 12) == 'hF)) begin lone_pend = 1; lone_pc = m_pc; end
      end else if (m_ph == 1) begin
        if (m_jmp) m_klo = m_word % 256;
      end else if (m_ph == 3) begin
        m_word = int'(instr_i);
        if (m_jmp) begin
          m_pc = (int'(instr_i) % 4096) * 512 + m_klo * 2;
          m_live = 0; m_flush = 1;
        end else begin
          m_live = instr_valid_i;
          if (instr_valid_i) m_pc = (m_pc + 2) % (1 << 21);
        end
      end
      m_ph = (m_ph + 1) % 4;
    end
  end

  int targets[3] = '{'h0468AC, 'h1FFFFE, 'h000000};
  int tgt_i = 0, cyc = 0, post_tgt = 0;
  bit in_post = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      tgt_i = 0; in_post = 0; cyc = 0;
    end else if (!done) begin
      check(int'(pc_o) == m_pc, "R3 pc", int'(pc_o), m_pc);
      check(flush_o == m_flush, "R7 flush", flush_o, m_flush);
      check(int'(phase_o) == m_ph, "R2 phase", phase_o, m_ph);
      check(fetch_req_o == (m_ph == 0), "R2 fetch_req", fetch_req_o, m_ph == 0);
      check(fetch_addr_o == pc_o, "R2 fetch_addr", int'(fetch_addr_o), int'(pc_o));
      check(pc_o[0] == 1'b0, "R6 pc bit0", pc_o[0], 0);
      if (phase_o == 2'd0 && in_post && !flush_o) begin
        check(int'(pc_o) == (post_tgt + 2) % (1 << 21), "R9 dead cycle", int'(pc_o), (post_tgt + 2) % (1 << 21));
        in_post = 0;
      end
      if (flush_o) begin
        check(int'(pc_o) == targets[tgt_i], "R5 target", int'(pc_o), targets[tgt_i]);
        check(int'(pc_o[8:1]) == (targets[tgt_i] / 2) % 256, "R4 low byte", int'(pc_o[8:1]), (targets[tgt_i] / 2) % 256);
        post_tgt = int'(pc_o); in_post = 1;
        tgt_i = (tgt_i + 1) % 3;
      end
      if (phase_o == 2'd0 && lone_pend && !(m_ph == 0 && m_jmp)) begin
        check(!flush_o && (int'(pc_o) == lone_pc || int'(pc_o) == lone_pc + 2),
              "R8 lone word", int'(pc_o), lone_pc + 2);
        lone_pend = 0;
      end
      if (phase_o == 2'd0) cyc++;
    end
    instr_i = prog(int'(pc_o));
    instr_valid_i = !((cyc % 5 == 2) && !m_jmp && !in_post && !flush_o);
  end

  task automatic reset_and_check();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(pc_o == '0, "R1 pc", int'(pc_o), 0);
    check(phase_o == 2'd0, "R1 phase", phase_o, 0);
    check(flush_o == 1'b0, "R1 flush", flush_o, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    reset_and_check();
    repeat (400) @(negedge clk);
    reset_and_check();
    repeat (400) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule